// File: doc/BRIEF.md
# Multi-Cycle Integer Processor Core

This block is a 32-bit integer core. It runs one instruction at a time, and each instruction uses a class-dependent number of clock steps. The steps are fetch, decode with register read, execute or address generation, memory or branch completion, and write-back. Each step moves values into named holding registers:

- instruction word
- next sequential PC
- two operand latches
- sign-extended immediate
- ALU result
- branch condition
- load data

The supported instructions are register add and subtract, add-immediate, word load, word store and branch-if-equal. The core talks to a single-port word memory through an address, write data, a write strobe and read data. Read data must return combinationally for the address presented in the same cycle. Writes take effect at the rising clock edge while the strobe is high.

A testbench or debug harness can read any register through a combinational debug read port. A dedicated all-ones instruction word stops the core and raises a halt flag.

Top module: `mc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core presents address 0, write strobe low and halt low. In every fetch step the memory address equals the PC and the strobe is low.
- R2: Opcode 0 with func 0x20 writes rs+rt into rd, and func 0x22 writes rs-rt into rd. The fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and func [5:0]. Each takes five cycles.
- R3: Opcode 0x08 writes rs plus the sign-extended immediate [15:0] into rt in five cycles.
- R4: Opcode 0x23 loads the memory word at rs+sext(imm) into rt in five cycles. Write-back always follows a memory step.
- R5: Opcode 0x2B writes rt to the memory word at rs+sext(imm). The strobe is high for exactly one cycle, in the memory step, and the store retires after four cycles.
- R6: Opcode 0x04 compares rs and rt. If they are equal the PC becomes PC+4+(sext(imm)<<2), otherwise PC+4. It retires after four cycles, and the PC stays word aligned.
- R7: Register 0 always reads zero and ignores writes, including through the debug port.
- R8: The word 0xFFFFFFFF raises the halt flag after its decode step, two cycles after its fetch. From then on the flag, the PC and the memory stay unchanged until reset.
- R9: Any other opcode, or opcode 0 with another func, is a no-op that advances the PC by 4 after three cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 32 | Byte address to memory (PC in fetch, ALU result in memory step) |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Combinational memory read data |
| halt_o | output | 1 | Core stopped on the halt word |
| dbg_addr_i | input | 5 | Debug register index |
| dbg_data_o | output | 32 | Debug register value |

## Verification
The bench runs random programs against its own instruction-level model and compares every register, the data memory, the total cycle count and the number of store strobes. The cycle count exposes a core that sends stores or branches through write-back, or that lets no-ops reach the memory step. Directed programs cover the following, each with its likely fault:
- Negative and maximum immediates, where a zero-extending core computes wrong sums.
- A backward branch loop, where a wrong offset shift or a missing sign extension never terminates or lands off target.
- Writes to register 0, which a core without the zero guard would keep.
- A store below the base address.

After the halt word the bench keeps the clock running, to catch a core that resumes fetching or writes memory while halted.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W = 16;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_ADDI    = 6'h08;
  localparam logic [5:0] OP_LW      = 6'h23;
  localparam logic [5:0] OP_SW      = 6'h2B;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] FN_ADD     = 6'h20;
  localparam logic [5:0] FN_SUB     = 6'h22;

  typedef enum logic [2:0] {
    ST_IF, ST_ID, ST_EX, ST_MEM, ST_WB, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    CL_RR, CL_RI, CL_LD, CL_ST, CL_BR, CL_NOP
  } class_e;

  function automatic class_e classify(logic [31:0] ir);
    case (ir[31:26])
      OP_SPECIAL: classify = (ir[5:0] == FN_ADD || ir[5:0] == FN_SUB) ? CL_RR : CL_NOP;
      OP_ADDI:    classify = CL_RI;
      OP_LW:      classify = CL_LD;
      OP_SW:      classify = CL_ST;
      OP_BEQ:     classify = CL_BR;
      default:    classify = CL_NOP;
    endcase
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o,
  input  logic [AW-1:0] raddr_d_i,
  output logic [W-1:0]  rdata_d_o
);
  logic [W-1:0] q [DEPTH];

  // entry 0 is never written, so it holds its reset value of zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = q[raddr_a_i];
  assign rdata_b_o = q[raddr_b_i];
  assign rdata_d_o = q[raddr_d_i];
endmodule

// File: rtl/mc_exec.sv
module mc_exec
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  class_e       cls_i,
  input  logic [5:0]   func_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] imm_i,
  input  logic [W-1:0] npc_i,
  output logic [W-1:0] result_o,
  output logic         cond_o
);
  logic [W-1:0] diff;

  assign diff   = a_i - b_i;
  assign cond_o = (diff == '0);

  always_comb begin
    unique case (cls_i)
      CL_RR:               result_o = (func_i == FN_SUB) ? diff : a_i + b_i;
      CL_RI, CL_LD, CL_ST: result_o = a_i + imm_i;
      CL_BR:               result_o = npc_i + {imm_i[W-3:0], 2'b00};
      default:             result_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  class_e cls_i,
  input  logic   halt_word_i,
  output state_e state_o
);
  state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IF:   state_d = ST_ID;
      ST_ID:   state_d = halt_word_i ? ST_HALT : ST_EX;
      ST_EX:   state_d = (cls_i == CL_NOP) ? ST_IF : ST_MEM;
      ST_MEM:  state_d = (cls_i == CL_ST || cls_i == CL_BR) ? ST_IF : ST_WB;
      ST_WB:   state_d = ST_IF;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int DEPTH = NREG,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [W-1:0]  mem_addr_o,
  output logic [W-1:0]  mem_wdata_o,
  output logic          mem_we_o,
  input  logic [W-1:0]  mem_rdata_i,
  output logic          halt_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [W-1:0]  dbg_data_o
);
  state_e       state_q;
  class_e       cls;
  logic [31:0]  ir_q;
  logic [W-1:0] pc_q, npc_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic         cond_q;
  logic [W-1:0] rf_a, rf_b, ex_res, wb_data;
  logic         ex_cond, rf_we;
  logic [AW-1:0] rs, rt, rd, wb_addr;

  assign rs  = ir_q[21 +: AW];
  assign rt  = ir_q[16 +: AW];
  assign rd  = ir_q[11 +: AW];
  assign cls = classify(ir_q);

  mc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cls_i       (cls),
    .halt_word_i (&ir_q),
    .state_o     (state_q)
  );

  mc_exec #(.W(W)) u_exec (
    .cls_i    (cls),
    .func_i   (ir_q[5:0]),
    .a_i      (a_q),
    .b_i      (b_q),
    .imm_i    (imm_q),
    .npc_i    (npc_q),
    .result_o (ex_res),
    .cond_o   (ex_cond)
  );

  assign rf_we   = (state_q == ST_WB);
  assign wb_addr = (cls == CL_RR) ? rd : rt;
  assign wb_data = (cls == CL_LD) ? lmd_q : alu_q;

  mc_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (wb_addr),
    .wdata_i   (wb_data),
    .raddr_a_i (rs),
    .rdata_a_o (rf_a),
    .raddr_b_i (rt),
    .rdata_b_o (rf_b),
    .raddr_d_i (dbg_addr_i),
    .rdata_d_o (dbg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      cond_q <= 1'b0;
      lmd_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IF: begin
          ir_q  <= mem_rdata_i[31:0];
          npc_q <= pc_q + W'(4);
        end
        ST_ID: begin
          a_q   <= rf_a;
          b_q   <= rf_b;
          imm_q <= {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
        end
        ST_EX: begin
          alu_q  <= ex_res;
          cond_q <= ex_cond;
          if (cls == CL_NOP) pc_q <= npc_q;
        end
        ST_MEM: begin
          if (cls == CL_LD) lmd_q <= mem_rdata_i;
          if (cls == CL_ST) pc_q <= npc_q;
          if (cls == CL_BR) pc_q <= cond_q ? alu_q : npc_q;
        end
        ST_WB:   pc_q <= npc_q;
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = (state_q == ST_MEM) ? alu_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_we_o    = (state_q == ST_MEM) && (cls == CL_ST);
  assign halt_o      = (state_q == ST_HALT);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input state_e      state_i,
  input class_e      cls_i,
  input logic [31:0] pc_i,
  input logic [31:0] mem_addr_i,
  input logic        mem_we_i,
  input logic        halt_i,
  input logic [4:0]  dbg_addr_i,
  input logic [31:0] dbg_data_i
);
  assert_fetch_pc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IF |-> (mem_addr_i == pc_i) && !mem_we_i);

  assert_wb_after_mem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_WB |-> $past(state_i) == ST_MEM);

  assert_we_store_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> state_i == ST_MEM && cls_i == CL_ST);

  assert_store_retire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MEM && cls_i == CL_ST) |=> state_i == ST_IF);

  assert_branch_retire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MEM && cls_i == CL_BR) |=> state_i == ST_IF);

  assert_pc_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00);

  assert_r0_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_addr_i == 5'd0 |-> dbg_data_i == 32'd0);

  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> halt_i && $stable(pc_i) && !mem_we_i);

  assert_nop_retire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EX && cls_i == CL_NOP) |=> state_i == ST_IF);
endmodule

bind mc_core mc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state_q),
  .cls_i      (cls),
  .pc_i       (pc_q),
  .mem_addr_i (mem_addr_o),
  .mem_we_i   (mem_we_o),
  .halt_i     (halt_o),
  .dbg_addr_i (dbg_addr_i),
  .dbg_data_i (dbg_data_o)
);

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, halt;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  logic [31:0] mem  [256];
  logic [31:0] rmem [256];
  logic [31:0] rrf  [32];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mc_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .halt_o(halt),
    .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  localparam logic [31:0] HALT = 32'hFFFF_FFFF;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // instruction-level model built from the requirements
  task automatic ref_run(output int cyc, output int stores);
    logic [31:0] pc, ir, a, b, imm, ea;
    pc = 0; cyc = 0; stores = 0;
    for (int i = 0; i < 32; i++) rrf[i] = 0;
    for (int s = 0; s < 4000; s++) begin
      ir = rmem[pc[9:2]];
      if (ir == HALT) begin cyc += 2; return; end
      a = rrf[ir[25:21]]; b = rrf[ir[20:16]];
      imm = {{16{ir[15]}}, ir[15:0]}; ea = a + imm;
      case (ir[31:26])
        6'h00: begin
          if (ir[5:0] == 6'h20 || ir[5:0] == 6'h22) begin
            if (ir[15:11] != 0) rrf[ir[15:11]] = (ir[5:0] == 6'h20) ? a + b : a - b;
            cyc += 5;
          end else cyc += 3;
          pc += 4;
        end
        6'h08: begin if (ir[20:16] != 0) rrf[ir[20:16]] = ea; cyc += 5; pc += 4; end
        6'h23: begin if (ir[20:16] != 0) rrf[ir[20:16]] = rmem[ea[9:2]]; cyc += 5; pc += 4; end
        6'h2B: begin rmem[ea[9:2]] = b; stores++; cyc += 4; pc += 4; end
        6'h04: begin pc = (a == b) ? pc + 4 + {imm[29:0], 2'b00} : pc + 4; cyc += 4; end
        default: begin cyc += 3; pc += 4; end
      endcase
    end
    cyc = -1;
  endtask

  task automatic run_case(string tag);
    int exp_cyc, exp_st, n, we_n;
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) rmem[i] = mem[i];
    ref_run(exp_cyc, exp_st);
    #1;
    check("R1", {tag, " reset addr"}, mem_addr, 0);
    check("R1", {tag, " reset we"}, {31'd0, mem_we}, 0);
    check("R1", {tag, " reset halt"}, {31'd0, halt}, 0);
    @(negedge clk); rst_ni = 1'b1;
    n = 0; we_n = 0;
    for (int k = 0; k < 6000; k++) begin
      if (mem_we) we_n++;
      @(posedge clk); n++;
      @(negedge clk);
      if (halt) break;
    end
    check("R8", {tag, " halted"}, {31'd0, halt}, 1);
    check("R4", {tag, " cycle count"}, n, exp_cyc);
    check("R5", {tag, " store strobes"}, we_n, exp_st);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8", {tag, " halt held"}, {31'd0, halt}, 1);
      check("R8", {tag, " no write while halted"}, {31'd0, mem_we}, 0);
    end
    for (int r = 0; r < 32; r++) begin
      dbg_addr = 5'(r); #1;
      check(r == 0 ? "R7" : "R2", $sformatf("%s reg %0d", tag, r), dbg_data, rrf[r]);
    end
    for (int w = 64; w < 256; w++)
      check("R5", $sformatf("%s mem word %0d", tag, w), mem[w], rmem[w]);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i >= 128) ? $urandom : HALT;
  endtask

  initial begin
    void'($urandom(32'h1357_2468));
    begin : watchdog
      fork
        begin
          #(8 * 190000);
          n_chk++; n_bad++;
          $display("FAIL watchdog expired actual=running expected=done");
          $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      join_none
    end

    // R2 R3 R7: sign extension, add/sub, writes to r0
    clear_mem();
    mem[0] = enc_i(6'h08, 0, 2, -5);
    mem[1] = enc_i(6'h08, 0, 3, 16'h7FFF);
    mem[2] = enc_r(2, 3, 4, 6'h20);
    mem[3] = enc_r(2, 3, 5, 6'h22);
    mem[4] = enc_r(0, 3, 6, 6'h22);
    mem[5] = enc_r(3, 3, 0, 6'h20);
    mem[6] = enc_i(6'h08, 3, 0, 9);
    mem[7] = enc_r(1, 2, 7, 6'h01);   // R9 unknown func
    mem[8] = enc_i(6'h3E, 2, 8, 3);   // R9 unknown opcode
    run_case("R2/R3 alu");

    // R4 R5: load/store incl. negative offset
    clear_mem();
    mem[0] = enc_i(6'h08, 0, 1, 512);
    mem[1] = enc_i(6'h08, 0, 2, -100);
    mem[2] = enc_i(6'h2B, 1, 2, 8);
    mem[3] = enc_i(6'h23, 1, 3, 8);
    mem[4] = enc_i(6'h23, 1, 0, 8);
    mem[5] = enc_i(6'h2B, 1, 3, -4);
    mem[6] = enc_i(6'h23, 1, 9, 40);
    run_case("R4/R5 mem");

    // R6: backward loop and forward skip
    clear_mem();
    mem[0] = enc_i(6'h08, 0, 2, 3);
    mem[1] = enc_i(6'h08, 2, 2, -1);
    mem[2] = enc_i(6'h08, 4, 4, 7);
    mem[3] = enc_i(6'h04, 2, 0, 1);
    mem[4] = enc_i(6'h04, 0, 0, -4);
    mem[5] = enc_i(6'h04, 0, 0, 1);
    mem[6] = enc_i(6'h08, 0, 5, 99);
    mem[7] = enc_i(6'h08, 0, 6, 11);
    run_case("R6 branch");

    // random programs
    for (int p = 0; p < 6; p++) begin
      clear_mem();
      mem[0] = enc_i(6'h08, 0, 1, 512);
      for (int i = 1; i <= 40; i++) begin
        int kind, d, s1, s2;
        kind = $urandom_range(0, 7);
        d = $urandom_range(0, 31); if (d == 1) d = 2;
        s1 = $urandom_range(0, 31); s2 = $urandom_range(0, 31);
        case (kind)
          0: mem[i] = enc_r(s1, s2, d, 6'h20);
          1: mem[i] = enc_r(s1, s2, d, 6'h22);
          2, 3: mem[i] = enc_i(6'h08, s1, d, $urandom_range(0, 65535));
          4: mem[i] = enc_i(6'h23, 1, d, 4 * $urandom_range(0, 63));
          5: mem[i] = enc_i(6'h2B, 1, s2, 4 * $urandom_range(0, 63));
          6: mem[i] = enc_i(6'h04, s1, ($urandom_range(0, 1) != 0) ? s1 : s2, $urandom_range(0, 2));
          default: mem[i] = enc_i(6'h3D, s1, d, 5);
        endcase
      end
      run_case($sformatf("R2/R6 random %0d", p));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule